// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Front End

This block sits between an 8-bit microcontroller running in expanded multiplexed mode and a byte-wide memory core. The controller uses eight shared pins for two things: first the low address byte, then data. Five more pins carry the high address bits. While the address strobe is high, the full 13-bit address flows through to the core. When the strobe falls, the address is frozen. After that the shared pins act as a data port under the control of chip enable, an E clock and a read/not-write line.

All controller-side inputs cross into the system clock domain through a parameterised synchroniser chain. Every output is registered. The shared pins are modelled as a split input, output and output-enable, and a pad ring combines them. A read drives the core's read data onto the bus. A write produces a single-cycle strobe on the falling edge of E, together with the byte sampled from the bus. A standby flag is raised when the chip is both deselected and idle.

Top module: `mxbus_front`

## Requirements
- R1: While the address strobe is high, `addr_o` equals `{hi_addr_i, ad_i}`, three clock cycles after the inputs change. `hi_addr_i` forms bits 12:8 and `ad_i` forms bits 7:0.
- R2: After the address strobe falls, `addr_o` holds the last address seen while the strobe was high, even if `ad_i` or `hi_addr_i` change. It holds until the strobe rises again.
- R3: `ad_oe` and `rd_o` are 1 when all of the following hold: chip enable high, read/not-write high, E high, strobe low and device select low. In that state `ad_o` carries `rd_data_i`.
- R4: If any one of the R3 conditions is absent, `ad_oe` and `rd_o` are 0 and `ad_o` is zero.
- R5: A falling edge of E produces exactly one clock cycle of `wr_o` when, at that edge, chip enable is high, read/not-write is low, strobe is low and device select is low. `wdata_o` then holds the `ad_i` value present at that edge.
- R6: With chip enable low, no write pulse is produced, whatever E and read/not-write do.
- R7: With device select high, no read enable and no write pulse are produced.
- R8: `standby_o` is 1 exactly when chip enable is low and the address strobe is low, after the same three-cycle latency.
- R9: While `rst` is high, `addr_o`, `ad_oe`, `rd_o`, `wr_o` and `standby_o` are all 0.
- R10: A rising edge of E produces no write pulse, and a falling edge of E with read/not-write high produces no write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 8 | Shared pins, input side (low address or write data) |
| ad_o | output | 8 | Shared pins, output side (read data) |
| ad_oe | output | 1 | Output enable for the shared pins |
| hi_addr_i | input | 5 | Dedicated high address pins |
| strobe_i | input | 1 | Address strobe; address passes while high |
| cen_i | input | 1 | Chip enable, active high |
| e_i | input | 1 | E clock from the controller |
| rnw_i | input | 1 | 1 = read, 0 = write |
| dsel_i | input | 1 | Device select; must be low for operation |
| rd_data_i | input | 8 | Read data from the memory core |
| addr_o | output | 13 | Internal address to the core |
| rd_o | output | 1 | Read strobe to the core |
| wr_o | output | 1 | Single-cycle write strobe to the core |
| wdata_o | output | 8 | Byte to be written |
| standby_o | output | 1 | Low-power standby indication |

## Verification
The bench changes the shared pins to data values after the strobe falls. A latch that stayed transparent, or that sampled one cycle late, would then show data bytes in `addr_o`. Read gating is tested by removing one enabling condition at a time. A decoder that ignores E, device select or the strobe would drive the bus during address phases or while the chip is deselected. Write strobes are counted over whole E cycles. A detector keyed to the wrong edge, one that stretches the pulse, or one that misses the chip-enable or read/not-write gating would show the wrong count. Standby is checked in all four combinations of chip enable and strobe.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef struct packed {
    logic as;
    logic ce;
    logic e;
    logic rnw;
    logic sel;
  } ctl_t;
  localparam int CTL_W = 5;
endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mxb_addr_latch.sv
module mxb_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 5,
  localparam int AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            as_s,
  input  logic [LO_W-1:0] lo_s,
  input  logic [HI_W-1:0] hi_s,
  output logic [AW-1:0]   addr_q
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (as_s) addr_q <= {hi_s, lo_s};
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !as_s |=> $stable(addr_q));

  // R1
  addr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    as_s |=> (addr_q == $past({hi_s, lo_s})));
endmodule

// File: rtl/mxb_data_ctl.sv
module mxb_data_ctl
  import mxb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          cs,
  input  logic [DW-1:0] bus_s,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          standby_o
);
  logic e_d;
  logic active;
  logic e_fall;
  logic rd_next;
  logic wr_next;

  always_comb begin
    active  = cs.ce & ~cs.sel & ~cs.as;
    e_fall  = e_d & ~cs.e;
    rd_next = active & cs.rnw & cs.e;
    wr_next = active & ~cs.rnw & e_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_d       <= 1'b0;
      ad_oe     <= 1'b0;
      rd_o      <= 1'b0;
      ad_o      <= '0;
      wr_o      <= 1'b0;
      wdata_o   <= '0;
      standby_o <= 1'b0;
    end else begin
      e_d       <= cs.e;
      ad_oe     <= rd_next;
      rd_o      <= rd_next;
      ad_o      <= rd_next ? rd_data : '0;
      wr_o      <= wr_next;
      standby_o <= ~cs.ce & ~cs.as;
      if (wr_next) wdata_o <= bus_s;
    end
  end

  // R5
  wr_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |=> !wr_o);

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ad_oe && wr_o));

  // R6
  wr_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> $past(cs.ce));

  // R8
  standby_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> !ad_oe);
endmodule

// File: rtl/mxbus_front.sv
module mxbus_front
  import mxb_pkg::*;
#(
  parameter int LO_W   = 8,
  parameter int HI_W   = 5,
  parameter int STAGES = 2,
  localparam int AW    = LO_W + HI_W,
  localparam int SW    = CTL_W + LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LO_W-1:0] ad_i,
  output logic [LO_W-1:0] ad_o,
  output logic            ad_oe,
  input  logic [HI_W-1:0] hi_addr_i,
  input  logic            strobe_i,
  input  logic            cen_i,
  input  logic            e_i,
  input  logic            rnw_i,
  input  logic            dsel_i,
  input  logic [LO_W-1:0] rd_data_i,
  output logic [AW-1:0]   addr_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic [LO_W-1:0] wdata_o,
  output logic            standby_o
);
  ctl_t            c_raw;
  ctl_t            c_s;
  logic [LO_W-1:0] lo_s;
  logic [HI_W-1:0] hi_s;
  logic [SW-1:0]   raw_bus;
  logic [SW-1:0]   sync_bus;

  always_comb begin
    c_raw.as  = strobe_i;
    c_raw.ce  = cen_i;
    c_raw.e   = e_i;
    c_raw.rnw = rnw_i;
    c_raw.sel = dsel_i;
    raw_bus   = {c_raw, hi_addr_i, ad_i};
  end

  mxb_sync #(.W(SW), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  assign c_s  = ctl_t'(sync_bus[SW-1 -: CTL_W]);
  assign hi_s = sync_bus[LO_W +: HI_W];
  assign lo_s = sync_bus[LO_W-1:0];

  mxb_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .as_s   (c_s.as),
    .lo_s   (lo_s),
    .hi_s   (hi_s),
    .addr_q (addr_o)
  );

  mxb_data_ctl #(.DW(LO_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .cs        (c_s),
    .bus_s     (lo_s),
    .rd_data   (rd_data_i),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .wdata_o   (wdata_o),
    .standby_o (standby_o)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ad_oe && !wr_o && !standby_o));

  // R7
  sel_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_o || rd_o) |-> !$past(c_s.sel));
endmodule

// File: tb/sim_mxbus_front.sv
module sim_mxbus_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ad_i = '0;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic [4:0]  hi_addr_i = '0;
  logic        strobe_i = 1'b0;
  logic        cen_i = 1'b0;
  logic        e_i = 1'b0;
  logic        rnw_i = 1'b1;
  logic        dsel_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic [12:0] addr_o;
  logic        rd_o;
  logic        wr_o;
  logic [7:0]  wdata_o;
  logic        standby_o;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mxbus_front u0 (
    .clk(clk), .rst(rst), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .hi_addr_i(hi_addr_i), .strobe_i(strobe_i), .cen_i(cen_i), .e_i(e_i),
    .rnw_i(rnw_i), .dsel_i(dsel_i), .rd_data_i(rd_data_i), .addr_o(addr_o),
    .rd_o(rd_o), .wr_o(wr_o), .wdata_o(wdata_o), .standby_o(standby_o)
  );

  always @(posedge clk) if (wr_o) wr_cnt <= wr_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_addr(input logic [12:0] a);
    strobe_i  = 1'b1;
    ad_i      = a[7:0];
    hi_addr_i = a[12:8];
    idle(5);
    strobe_i = 1'b0;
    idle(5);
  endtask

  task automatic t_reset;
    idle(3);
    chk("R9 addr", addr_o, 0);
    chk("R9 oe", ad_oe, 0);
    chk("R9 rd", rd_o, 0);
    chk("R9 wr", wr_o, 0);
    chk("R9 standby", standby_o, 0);
    rst = 1'b0;
  endtask

  task automatic t_addr_pass;
    cen_i = 1'b1;
    strobe_i = 1'b1;
    ad_i = 8'h3C; hi_addr_i = 5'h15;
    idle(2);
    chk("R1 latency not yet", addr_o == 13'h153C, 0);
    idle(1);
    chk("R1 pass after 3 cycles", addr_o, 13'h153C);
    ad_i = 8'hC3; hi_addr_i = 5'h0A;
    idle(4);
    chk("R1 follows change", addr_o, 13'h0AC3);
  endtask

  task automatic t_addr_hold;
    put_addr(13'h1E5A);
    chk("R2 latched", addr_o, 13'h1E5A);
    ad_i = 8'hFF; hi_addr_i = 5'h01;
    idle(6);
    chk("R2 held while strobe low", addr_o, 13'h1E5A);
    strobe_i = 1'b1;
    idle(4);
    chk("R2 released on rise", addr_o, 13'h01FF);
    strobe_i = 1'b0;
    idle(4);
  endtask

  task automatic t_read;
    put_addr(13'h0123);
    rd_data_i = 8'hA5; rnw_i = 1'b1; e_i = 1'b1;
    idle(5);
    chk("R3 oe", ad_oe, 1);
    chk("R3 rd", rd_o, 1);
    chk("R3 data", ad_o, 8'hA5);
    rd_data_i = 8'h5A;
    idle(2);
    chk("R3 data follows core", ad_o, 8'h5A);
    e_i = 1'b0; idle(5);
    chk("R4 E low floats", ad_oe, 0);
    chk("R4 ad_o zero", ad_o, 0);
    e_i = 1'b1; rnw_i = 1'b0; idle(5);
    chk("R4 rnw low floats", ad_oe, 0);
    rnw_i = 1'b1; cen_i = 1'b0; idle(5);
    chk("R4 ce low floats", rd_o, 0);
    cen_i = 1'b1; dsel_i = 1'b1; idle(5);
    chk("R7 sel blocks read", ad_oe, 0);
    dsel_i = 1'b0; strobe_i = 1'b1; idle(5);
    chk("R4 strobe high floats", ad_oe, 0);
    strobe_i = 1'b0; idle(5);
    chk("R3 restored", ad_oe, 1);
    e_i = 1'b0; idle(4);
  endtask

  task automatic e_cycle(input logic [7:0] d, input logic rnw);
    ad_i = d; rnw_i = rnw;
    idle(4);
    e_i = 1'b1; idle(5);
    e_i = 1'b0; idle(6);
  endtask

  task automatic t_write;
    int base;
    put_addr(13'h0777);
    base = wr_cnt;
    ad_i = 8'h96; rnw_i = 1'b0;
    idle(4);
    e_i = 1'b1; idle(5);
    chk("R10 no pulse on E rise", wr_cnt - base, 0);
    e_i = 1'b0; idle(6);
    chk("R5 one pulse", wr_cnt - base, 1);
    chk("R5 data", wdata_o, 8'h96);
    e_cycle(8'h4B, 1'b0);
    chk("R5 second pulse", wr_cnt - base, 2);
    chk("R5 second data", wdata_o, 8'h4B);
    e_cycle(8'h11, 1'b1);
    chk("R10 read cycle no write", wr_cnt - base, 2);
    chk("R10 wdata kept", wdata_o, 8'h4B);
  endtask

  task automatic t_write_blocked;
    int base;
    base = wr_cnt;
    cen_i = 1'b0;
    e_cycle(8'h22, 1'b0);
    chk("R6 ce low no write", wr_cnt - base, 0);
    chk("R6 wdata kept", wdata_o, 8'h4B);
    cen_i = 1'b1; dsel_i = 1'b1;
    e_cycle(8'h33, 1'b0);
    chk("R7 sel high no write", wr_cnt - base, 0);
    dsel_i = 1'b0;
    rnw_i = 1'b1;
    idle(4);
  endtask

  task automatic t_standby;
    cen_i = 1'b0; strobe_i = 1'b0; idle(5);
    chk("R8 ce0 as0", standby_o, 1);
    strobe_i = 1'b1; idle(5);
    chk("R8 ce0 as1", standby_o, 0);
    cen_i = 1'b1; idle(5);
    chk("R8 ce1 as1", standby_o, 0);
    strobe_i = 1'b0; idle(5);
    chk("R8 ce1 as0", standby_o, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_addr_pass();
    t_addr_hold();
    t_read();
    t_write();
    t_write_blocked();
    t_standby();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule